// File: doc/BRIEF.md
# Oversampled Parallel Flash Bus Front End

This block sits between the pins of a parallel, NOR-style flash bus and the command engine of the flash. It watches three active-low strobes (chip select, output enable, write strobe), an address bus and the incoming half of a 16-bit data bus. A clock that runs much faster than any strobe samples all of these inputs. From them the block makes two kinds of event. A read request carries an address to the array. A write event carries an address and a data word to the command decoder. It also decides when the outward data bus is driven with the array's read data, and it raises an idle low-power flag once a read has been served.

In a write cycle, the address and the data are taken at different moments. The address is taken when the second of chip select and write strobe goes low. The data is taken when the first of the two returns high, and the write event is emitted at that same moment. The first read after reset needs a fresh falling edge on chip select before any data is produced, and so does the first read after a write event. The low-power flag costs nothing in read latency. A read that starts while the flag is set is served after the same number of cycles as any other read.

Top module: `flash_bus_front`

## Requirements
- R1: While `rst_n` is low, `dq_oe`, `rd_req`, `wr_evt` and `low_power` are all 0.
- R2: `dq_oe` is 1 only while chip select and output enable are both sampled low. While `dq_oe` is 1, `dq_out` equals `rd_data`, and the array returns `rd_data` for the address given on `rd_addr`.
- R3: When output enable goes high (a value of 1 means inactive), `dq_oe` is 0 no later than SYNC_STAGES+1 clock cycles afterwards.
- R4: A write cycle's address is the value of `bus_addr` at the falling edge of whichever of chip select and write strobe falls last. Later address changes within the cycle do not change `wr_addr`.
- R5: The write data is the value of `dq_in` at the rising edge of whichever of chip select and write strobe rises first. That edge produces exactly one single-cycle `wr_evt`. If both strobes change in the same sampled cycle, the change counts as one edge for both rules.
- R6: A write cycle starts only if output enable is sampled high when chip select and write strobe both become low. Otherwise no `wr_evt` follows and `dq_oe` stays 0.
- R7: If output enable goes low during an active write cycle, the block ignores it. `dq_oe` stays 0 and the write still ends with its `wr_evt`.
- R8: After reset, a read window (chip select and output enable low, write strobe high) produces no `rd_req` and no bus drive until chip select has gone from high to low.
- R9: After a `wr_evt`, the next read likewise needs a new high-to-low transition on chip select before `rd_req` or `dq_oe` can occur.
- R10: Once reads are enabled, `rd_req` pulses for one cycle, with `rd_addr` set to the sampled address. It pulses when the read window opens, and again at every address change while the window stays open.
- R11: `low_power` becomes 1 two cycles after a `rd_req` if no input transition occurs in between. It returns to 0 after any transition on a strobe or on the address, and it is 0 when the `rd_req` of a wake-up address change is seen.
- R12: From an address change at the pins to `rd_req`, the delay is SYNC_STAGES+1 cycles. The delay is the same whether or not `low_power` was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| bus_we_n | input | 1 | Write strobe, active low, asynchronous |
| bus_addr | input | ADDR_W | Address bus from the host |
| dq_in | input | DATA_W | Incoming half of the data bus |
| dq_out | output | DATA_W | Read data to be placed on the bus |
| dq_oe | output | 1 | Bus drive enable for dq_out (0 = high impedance) |
| rd_req | output | 1 | One-cycle read request to the array |
| rd_addr | output | ADDR_W | Address of the latest read request |
| rd_data | input | DATA_W | Array data for rd_addr |
| wr_evt | output | 1 | One-cycle write-cycle event to the command engine |
| wr_addr | output | ADDR_W | Address captured for the write cycle |
| wr_data | output | DATA_W | Data captured for the write cycle |
| low_power | output | 1 | Automatic idle low-power indication |

## Verification
A write tracker stuck in its active state would keep `dq_oe` at 0 through later read windows, and it would hold back `wr_evt` until the next strobe rise. Both faults show within a few cycles of the end of the write. A wrong read-enable state shows as a missing or an extra `rd_req` within SYNC_STAGES+1 cycles of the chip-select fall. A synchronizer or edge stage of the wrong length shifts the measured read latency away from SYNC_STAGES+1. A wrong order between the address latch and the data latch shows as a `wr_addr` or `wr_data` that holds the later value instead of the value at the deciding edge.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
   // Strobe bundle, all active low; ce_n is the most significant bit.
   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
   } strobe_t;

   localparam int STROBE_W = $bits(strobe_t);

   // Cycles the edge stage waits after reset before reporting any edge.
   function automatic int settle_cycles(input int stages);
      return stages + 1;
   endfunction
endpackage

// File: rtl/fbi_sync.sv
module fbi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fbi_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fbi_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= RST_VAL;
               else        stg[gi] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= RST_VAL;
               else        stg[gi] <= stg[gi-1];
            end
         end
      end
   endgenerate

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/fbi_edge.sv
module fbi_edge #(
   parameter int          W       = 3,
   parameter int          SETTLE  = 3,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall,
   output logic         primed
);
   localparam int CW = $clog2(SETTLE + 1) + 1;

   generate
      if (SETTLE < 1) begin : g_bad_settle
         $error("fbi_edge: SETTLE must be positive");
      end
   endgenerate

   logic [W-1:0]  prev;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= RST_VAL;
         cnt  <= '0;
      end else begin
         prev <= d;
         if (cnt != CW'(SETTLE)) cnt <= cnt + 1'b1;
      end
   end

   assign primed = (cnt == CW'(SETTLE));
   assign rise   = primed ? (d & ~prev) : '0;
   assign fall   = primed ? (~d & prev) : '0;
endmodule

// File: rtl/fbi_write_track.sv
module fbi_write_track #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              primed,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              active,
   output logic              wr_end,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic both_low;
   logic both_low_q;
   logic start;

   // Last fall: both strobes low now but not in the previous sample.
   assign both_low = ~ce_n & ~we_n;
   assign start    = primed & both_low & ~both_low_q & ~active;
   // First rise: either strobe leaves the low/low state.
   assign wr_end   = active & ~both_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_low_q <= 1'b0;
         active     <= 1'b0;
         wr_evt     <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
      end else begin
         both_low_q <= both_low;
         wr_evt     <= wr_end;
         if (start && oe_n) begin
            active  <= 1'b1;
            wr_addr <= addr;
         end else if (wr_end) begin
            active  <= 1'b0;
            wr_data <= data;
         end
      end
   end
endmodule

// File: rtl/fbi_read_ctrl.sv
module fbi_read_ctrl #(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              primed,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              ce_fall,
   input  logic              strobe_edge,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_active,
   input  logic              wr_end,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              low_power
);
   logic [ADDR_W-1:0] addr_q;
   logic              window;
   logic              window_q;
   logic              armed_q;
   logic              armed;
   logic              addr_chg;
   logic              activity;
   logic              issue;
   logic              rd_req_q;

   assign addr_chg = primed & (addr != addr_q);
   assign activity = strobe_edge | addr_chg;
   assign window   = ~ce_n & ~oe_n & we_n & ~wr_active;
   assign armed    = ~wr_end & (armed_q | ce_fall);
   assign issue    = window & armed & (~window_q | addr_chg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         window_q  <= 1'b0;
         armed_q   <= 1'b0;
         rd_req    <= 1'b0;
         rd_req_q  <= 1'b0;
         rd_addr   <= '0;
         dq_oe     <= 1'b0;
         low_power <= 1'b0;
      end else begin
         addr_q   <= addr;
         window_q <= window;
         armed_q  <= armed;
         rd_req   <= issue;
         rd_req_q <= rd_req;
         dq_oe    <= window & armed;
         if (issue) rd_addr <= addr;
         if (activity)      low_power <= 1'b0;
         else if (rd_req_q) low_power <= 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dq_out <= '0;
            else        dq_out <= rd_data;
         end
      end else begin : g_out_pass
         assign dq_out = rd_data;
      end
   endgenerate
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
   import fbi_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce_n,
   input  logic              bus_oe_n,
   input  logic              bus_we_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_evt,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              low_power
);
   localparam int BUS_W  = ADDR_W + DATA_W;
   localparam int SETTLE = settle_cycles(SYNC_STAGES);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("flash_bus_front: ADDR_W and DATA_W must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("flash_bus_front: SYNC_STAGES must be at least 2");
      end
   endgenerate

   strobe_t             str_raw;
   strobe_t             str_s;
   strobe_t             str_rise;
   strobe_t             str_fall;
   logic [BUS_W-1:0]    bus_s;
   logic [ADDR_W-1:0]   addr_s;
   logic [DATA_W-1:0]   data_s;
   logic                ce_s;
   logic                oe_s;
   logic                we_s;
   logic                primed;
   logic                wr_active;
   logic                wr_end;

   assign str_raw = '{ce_n: bus_ce_n, oe_n: bus_oe_n, we_n: bus_we_n};

   fbi_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_str (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (str_raw),
      .dout (str_s)
   );

   // Address and data ride a pipeline as deep as the strobes so that
   // each strobe edge meets the bus value present when it happened.
   fbi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({bus_addr, dq_in}),
      .dout (bus_s)
   );

   assign addr_s = bus_s[BUS_W-1:DATA_W];
   assign data_s = bus_s[DATA_W-1:0];
   assign ce_s   = str_s.ce_n;
   assign oe_s   = str_s.oe_n;
   assign we_s   = str_s.we_n;

   fbi_edge #(.W(STROBE_W), .SETTLE(SETTLE), .RST_VAL('1)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (str_s),
      .rise  (str_rise),
      .fall  (str_fall),
      .primed(primed)
   );

   fbi_write_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .primed (primed),
      .ce_n   (ce_s),
      .oe_n   (oe_s),
      .we_n   (we_s),
      .addr   (addr_s),
      .data   (data_s),
      .active (wr_active),
      .wr_end (wr_end),
      .wr_evt (wr_evt),
      .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   fbi_read_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .primed     (primed),
      .ce_n       (ce_s),
      .oe_n       (oe_s),
      .we_n       (we_s),
      .ce_fall    (str_fall.ce_n),
      .strobe_edge(|{str_rise, str_fall}),
      .addr       (addr_s),
      .wr_active  (wr_active),
      .wr_end     (wr_end),
      .rd_data    (rd_data),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .dq_oe      (dq_oe),
      .dq_out     (dq_out),
      .low_power  (low_power)
   );
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              oe_s,
   input logic              wr_active,
   input logic              dq_oe,
   input logic              rd_req,
   input logic              wr_evt,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              low_power
);
   // R2: drive only follows a sampled chip-select-low and output-enable-low
   assert_drive_needs_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!$past(ce_s) && !$past(oe_s)));

   // R3: output enable high in one sample leaves the bus undriven in the next
   assert_oe_high_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_s) |-> !dq_oe);

   // R4: the captured write address holds still when the event fires
   assert_addr_stable_at_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |-> $stable(wr_addr));

   // R5: each write event lasts a single cycle
   assert_single_write_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !wr_evt);

   // R7: no drive while a write cycle was in progress
   assert_no_drive_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_active) |-> !dq_oe);

   // R10: a read request comes with the bus being driven
   assert_req_with_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> dq_oe);

   // R11: low power is entered only two cycles after a read request
   assert_lp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_power) |-> $past(rd_req, 2));
endmodule

bind flash_bus_front flash_bus_front_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_s     (ce_s),
   .oe_s     (oe_s),
   .wr_active(wr_active),
   .dq_oe    (dq_oe),
   .rd_req   (rd_req),
   .wr_evt   (wr_evt),
   .wr_addr  (wr_addr),
   .low_power(low_power)
);

// File: tb/sim_flash_bus_front.sv
module sim_flash_bus_front;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 20;
   localparam int DW  = 16;
   localparam int LAT = 3; // SYNC_STAGES + 1 with default parameters

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b0;
   logic          oe_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          wr_evt;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          low_power;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int oe_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Array model: data is a fixed function of the requested address.
   assign rd_data = rd_addr[DW-1:0] ^ 16'h5A3C;

   flash_bus_front u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
      .bus_addr(addr), .dq_in(din),
      .dq_out(dq_out), .dq_oe(dq_oe),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
      .low_power(low_power)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req) rd_cnt++;
         if (wr_evt) wr_cnt++;
         if (dq_oe)  oe_cnt++;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure_lat(input logic [AW-1:0] a, output int lat);
      @(negedge clk);
      addr = a;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!rd_req && lat < 20);
   endtask

   task automatic t_reset();
      cyc(3);
      check(dq_oe == 1'b0 && rd_req == 1'b0, "R1 reset read outputs", {dq_oe, rd_req}, 0);
      check(wr_evt == 1'b0 && low_power == 1'b0, "R1 reset write/lp outputs", {wr_evt, low_power}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(6);
   endtask

   task automatic t_first_read();
      int r0;
      int o0;
      r0 = rd_cnt; o0 = oe_cnt;
      addr = 20'h00042;
      oe_n = 1'b0;
      cyc(8);
      check(rd_cnt == r0, "R8 no read before chip-select fall", rd_cnt, r0);
      check(oe_cnt == o0, "R8 no drive before chip-select fall", oe_cnt, o0);
      ce_n = 1'b1;
      cyc(5);
      ce_n = 1'b0;
      cyc(6);
      check(rd_cnt == r0 + 1, "R10 read after chip-select fall", rd_cnt, r0 + 1);
      check(rd_addr == 20'h00042, "R10 read address", rd_addr, 20'h00042);
      check(dq_oe == 1'b1, "R2 bus driven in read window", dq_oe, 1);
      check(dq_out == (16'h0042 ^ 16'h5A3C), "R2 read data", dq_out, 16'h0042 ^ 16'h5A3C);
   endtask

   task automatic t_low_power();
      int lat;
      check(low_power == 1'b1, "R11 low power after idle read", low_power, 1);
      measure_lat(20'h00137, lat);
      check(lat == LAT, "R12 wake latency from low power", lat, LAT);
      check(low_power == 1'b0, "R11 low power left on address change", low_power, 0);
      check(rd_addr == 20'h00137, "R10 read on address change", rd_addr, 20'h00137);
      measure_lat(20'h00138, lat);
      check(lat == LAT, "R12 back-to-back latency", lat, LAT);
      check(dq_out == (16'h0138 ^ 16'h5A3C), "R2 data follows new address", dq_out, 16'h0138 ^ 16'h5A3C);
      cyc(6);
      check(low_power == 1'b1, "R11 low power re-entered", low_power, 1);
   endtask

   task automatic t_oe_release();
      int r0;
      r0 = rd_cnt;
      oe_n = 1'b1;
      cyc(LAT + 1);
      check(dq_oe == 1'b0, "R3 bus released on output enable high", dq_oe, 0);
      check(low_power == 1'b0, "R11 low power left on strobe edge", low_power, 0);
      check(rd_cnt == r0, "R3 no read with output enable high", rd_cnt, r0);
   endtask

   task automatic t_we_last();
      int w0;
      w0 = wr_cnt;
      addr = 20'h00123; din = 16'hBEEF;
      we_n = 1'b0;
      cyc(5);
      addr = 20'h00456;
      cyc(3);
      we_n = 1'b1; din = 16'hCAFE;
      @(negedge clk);
      din = 16'h0000;
      cyc(6);
      check(wr_cnt == w0 + 1, "R5 one event on write strobe rise", wr_cnt, w0 + 1);
      check(wr_addr == 20'h00123, "R4 address at write strobe fall", wr_addr, 20'h00123);
      check(wr_data == 16'hCAFE, "R5 data at write strobe rise", wr_data, 16'hCAFE);
   endtask

   task automatic t_ce_last();
      int w0;
      ce_n = 1'b1;
      cyc(5);
      w0 = wr_cnt;
      addr = 20'h00200; we_n = 1'b0;
      cyc(5);
      addr = 20'h00300; ce_n = 1'b0;
      cyc(5);
      addr = 20'h00301; din = 16'h1111;
      cyc(3);
      ce_n = 1'b1; din = 16'h2222;
      @(negedge clk);
      din = 16'h3333;
      cyc(3);
      we_n = 1'b1;
      cyc(6);
      check(wr_cnt == w0 + 1, "R5 single event when chip select rises first", wr_cnt, w0 + 1);
      check(wr_addr == 20'h00300, "R4 address at chip-select fall", wr_addr, 20'h00300);
      check(wr_data == 16'h2222, "R5 data at chip-select rise", wr_data, 16'h2222);
   endtask

   task automatic t_simultaneous();
      int w0;
      w0 = wr_cnt;
      addr = 20'h000AA; din = 16'h0F0F;
      ce_n = 1'b0; we_n = 1'b0;
      cyc(5);
      addr = 20'h000AB;
      cyc(2);
      ce_n = 1'b1; we_n = 1'b1;
      cyc(6);
      check(wr_cnt == w0 + 1, "R5 simultaneous strobes give one event", wr_cnt, w0 + 1);
      check(wr_addr == 20'h000AA, "R4 simultaneous fall address", wr_addr, 20'h000AA);
      check(wr_data == 16'h0F0F, "R5 simultaneous rise data", wr_data, 16'h0F0F);
   endtask

   task automatic t_oe_low_no_write();
      int w0;
      int o0;
      w0 = wr_cnt; o0 = oe_cnt;
      oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
      din = 16'h9999;
      cyc(6);
      ce_n = 1'b1; we_n = 1'b1;
      cyc(4);
      oe_n = 1'b1;
      cyc(6);
      check(wr_cnt == w0, "R6 no write with output enable low", wr_cnt, w0);
      check(oe_cnt == o0, "R6 no drive with write strobe low", oe_cnt, o0);
   endtask

   task automatic t_oe_in_write();
      int w0;
      int o0;
      int r0;
      ce_n = 1'b0;
      cyc(5);
      w0 = wr_cnt; o0 = oe_cnt;
      addr = 20'h00777; din = 16'h7777;
      we_n = 1'b0;
      cyc(5);
      oe_n = 1'b0;
      cyc(6);
      check(oe_cnt == o0, "R7 output enable ignored during write", oe_cnt, o0);
      we_n = 1'b1;
      cyc(6);
      check(wr_cnt == w0 + 1, "R7 write completes despite output enable", wr_cnt, w0 + 1);
      check(wr_data == 16'h7777, "R7 write data kept", wr_data, 16'h7777);
      r0 = rd_cnt;
      cyc(4);
      check(rd_cnt == r0, "R9 no read after write without chip-select fall", rd_cnt, r0);
      check(oe_cnt == o0, "R9 no drive after write", oe_cnt, o0);
      ce_n = 1'b1;
      cyc(5);
      ce_n = 1'b0;
      cyc(6);
      check(rd_cnt == r0 + 1, "R9 read resumes after chip-select fall", rd_cnt, r0 + 1);
      check(dq_oe == 1'b1, "R9 bus driven again", dq_oe, 1);
      check(dq_out == (16'h0777 ^ 16'h5A3C), "R2 data after re-arm", dq_out, 16'h0777 ^ 16'h5A3C);
   endtask

   initial begin
      t_reset();
      t_first_read();
      t_low_power();
      t_oe_release();
      t_we_last();
      t_ce_last();
      t_simultaneous();
      t_oe_low_no_write();
      t_oe_in_write();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule